// File: doc/BRIEF.md
# Sector Single-Bit ECC Repair Engine

This block acts on the status word that a NAND ECC checker produces after a 512-byte sector has been read into a local byte-wide RAM. On a start pulse it captures the word and a layout-select bit, then decodes a two-bit error class, a byte index and a bit index. When the class says one bit is wrong, it repairs that bit in place. It reads the byte, waits one cycle for the RAM's registered read, and writes the byte back with the reported bit inverted.

Two layouts share the same word. The main-area layout is selected with `spare_mode` low and the spare-area layout with `spare_mode` high. The result comes back as a one-cycle `done` pulse. `ok` says whether the sector may be used, and `err_class` holds the decoded class.

The start/done pair is a plain control handshake, not a stream. The block can hold only one request at a time. It has no back-pressure: a start seen while `busy` is high is dropped, not queued. The RAM port assumes read data appears one cycle after `ram_rd_en` and that a write completes at the clock edge where `ram_wr_en` is high.

Top module: `nand_ecc_fixer`

## Requirements
- R1: With `spare_mode` low, the class is taken from report bits [1:0], the byte index from bits [17:7] and the bit index from bits [6:4]; all other bits are ignored.
- R2: With `spare_mode` high, the class is taken from bits [3:2], the byte index from bits [24:21] and the bit index from bits [20:18]; all other bits are ignored.
- R3: Class 0 (clean) gives `ok`=1 with no RAM access, and `done` is high in the second cycle after the start edge.
- R4: Class 1 (single bit) with an index below the sector size replaces the indexed byte with that byte XOR (1 << bit index) and gives `ok`=1.
- R5: Class 2 (several bits) gives `ok`=0 and no RAM write.
- R6: Class 3 (check bytes damaged) gives `ok`=0 and no RAM write.
- R7: A repair raises `ram_rd_en` one cycle after the start edge's decode cycle and `ram_wr_en` two cycles after the read. `done` follows the write by one cycle, and `done` is always a single-cycle pulse.
- R8: `start` is ignored while `busy` is high: one request gives exactly one `done` and no other RAM write.
- R9: The report and `spare_mode` are captured on the accepted start; changing them afterwards does not affect the request.
- R10: After reset `ok` and `err_class` are 0. Both then hold their result from a request's decode until the next accepted request is decoded.
- R11: Class 1 with a byte index at or above the sector size gives `ok`=0 with `err_class`=1 and no RAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| report | input | 32 | ECC status word from the checker |
| spare_mode | input | 1 | 0 selects the main-area layout, 1 the spare-area layout |
| busy | output | 1 | High from the accepted start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Sector usable after this request |
| err_class | output | 2 | Decoded class: 0 clean, 1 single, 2 multiple, 3 check area |
| ram_addr | output | 9 | Sector RAM byte address |
| ram_rd_en | output | 1 | RAM read request |
| ram_wr_en | output | 1 | RAM write request |
| ram_wdata | output | 8 | Repaired byte |
| ram_rdata | input | 8 | RAM read data, one cycle after the read |

## Verification
The hardest situation to reach from the ports is a second start landing in the middle of a repair. Its report is itself a valid single-bit report aimed at a different byte. To get there, the bench raises start again during the read cycle of a repair and then checks that the second target byte is untouched and that only one done appears. A related case drives a different report and layout right after acceptance, to show the captured copy is used. Overlapping layouts are covered by filling the unselected layout's fields with a conflicting class.

// File: rtl/nef_pkg.sv
package nef_pkg;
  typedef enum logic [1:0] {
    ECC_CLEAN  = 2'd0,
    ECC_SINGLE = 2'd1,
    ECC_MULTI  = 2'd2,
    ECC_AREA   = 2'd3
  } ecc_class_e;

  localparam int NUM_LAYOUTS  = 2;
  localparam int LAYOUT_MAIN  = 0;
  localparam int LAYOUT_SPARE = 1;
  localparam int MAX_IDX_W    = 11;
  localparam int BIT_W        = 3;
  localparam int BYTE_W       = 1 << BIT_W;

  // field placement per layout, indexed by LAYOUT_*
  localparam int CLS_LSB_TBL [NUM_LAYOUTS] = '{0, 2};
  localparam int IDX_LSB_TBL [NUM_LAYOUTS] = '{7, 21};
  localparam int IDX_W_TBL   [NUM_LAYOUTS] = '{11, 4};
  localparam int BIT_LSB_TBL [NUM_LAYOUTS] = '{4, 18};

  typedef struct packed {
    ecc_class_e             cls;
    logic [MAX_IDX_W-1:0]   idx;
    logic [BIT_W-1:0]       bitpos;
  } ecc_fault_t;
endpackage

// File: rtl/nef_layout.sv
module nef_layout
  import nef_pkg::*;
#(
  parameter int REPORT_W = 32,
  parameter int CLS_LSB  = 0,
  parameter int IDX_LSB  = 7,
  parameter int IDX_W    = 11,
  parameter int BIT_LSB  = 4
) (
  input  logic [REPORT_W-1:0] report,
  output ecc_fault_t          fault
);
  logic unused_report;
  assign unused_report = ^report;

  always_comb begin
    fault.cls    = ecc_class_e'(report[CLS_LSB +: 2]);
    fault.idx    = MAX_IDX_W'(report[IDX_LSB +: IDX_W]);
    fault.bitpos = report[BIT_LSB +: BIT_W];
  end
endmodule

// File: rtl/nef_decode.sv
module nef_decode
  import nef_pkg::*;
#(
  parameter int REPORT_W   = 32,
  parameter int SECT_BYTES = 512
) (
  input  logic [REPORT_W-1:0] report,
  input  logic                spare_sel,
  output ecc_fault_t          fault,
  output logic                in_range
);
  ecc_fault_t per_layout [NUM_LAYOUTS];

  for (genvar g = 0; g < NUM_LAYOUTS; g++) begin : g_layout
    nef_layout #(
      .REPORT_W (REPORT_W),
      .CLS_LSB  (CLS_LSB_TBL[g]),
      .IDX_LSB  (IDX_LSB_TBL[g]),
      .IDX_W    (IDX_W_TBL[g]),
      .BIT_LSB  (BIT_LSB_TBL[g])
    ) u_layout (
      .report (report),
      .fault  (per_layout[g])
    );
  end

  always_comb begin
    fault    = spare_sel ? per_layout[LAYOUT_SPARE] : per_layout[LAYOUT_MAIN];
    in_range = (32'(fault.idx) < 32'(SECT_BYTES));
  end
endmodule

// File: rtl/nef_onehot.sv
module nef_onehot #(
  parameter int SEL_W = 3,
  localparam int OUT_W = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  output logic [OUT_W-1:0] mask
);
  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    assign mask[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/nef_rmw_ctrl.sv
module nef_rmw_ctrl
  import nef_pkg::*;
#(
  parameter int REPORT_W = 32,
  parameter int ADDR_W   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [REPORT_W-1:0] report,
  input  logic                spare_mode,
  output logic [REPORT_W-1:0] rep_q,
  output logic                spare_q,
  input  ecc_fault_t          fault,
  input  logic                in_range,
  input  logic [BYTE_W-1:0]   mask,
  output logic                busy,
  output logic                done,
  output logic                ok,
  output logic [1:0]          err_class,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic                ram_rd_en,
  output logic                ram_wr_en,
  output logic [BYTE_W-1:0]   ram_wdata,
  input  logic [BYTE_W-1:0]   ram_rdata
);
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_READ, S_WAIT, S_WRITE, S_FIN
  } state_e;

  state_e           state;
  logic [BYTE_W-1:0] byte_q;
  logic             ok_q;
  ecc_class_e       cls_q;
  logic             repair;

  logic unused_idx_hi;
  assign unused_idx_hi = ^fault.idx;

  assign repair = (fault.cls == ECC_SINGLE) && in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      rep_q   <= '0;
      spare_q <= 1'b0;
      byte_q  <= '0;
      ok_q    <= 1'b0;
      cls_q   <= ECC_CLEAN;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          rep_q   <= report;
          spare_q <= spare_mode;
          state   <= S_CHECK;
        end
        S_CHECK: begin
          cls_q <= fault.cls;
          ok_q  <= (fault.cls == ECC_CLEAN) || repair;
          state <= repair ? S_READ : S_FIN;
        end
        S_READ:  state <= S_WAIT;
        S_WAIT: begin
          byte_q <= ram_rdata;
          state  <= S_WRITE;
        end
        S_WRITE: state <= S_FIN;
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign ok        = ok_q;
  assign err_class = cls_q;
  assign ram_addr  = fault.idx[ADDR_W-1:0];
  assign ram_rd_en = (state == S_READ);
  assign ram_wr_en = (state == S_WRITE);
  assign ram_wdata = byte_q ^ mask;

  a_r8_latch_stable_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(rep_q) && $stable(spare_q)));
  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |=> done);
  a_r7_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> $past(ram_rd_en, 2));
  a_r7_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_single_bit_flip: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> ($countones(ram_wdata ^ $past(ram_rdata)) == 1));
  a_r5_write_only_single: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> (err_class == ECC_SINGLE));
  a_r3_ok_class_clean_or_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> (err_class inside {ECC_CLEAN, ECC_SINGLE}));
  a_r6_ram_ports_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_rd_en, ram_wr_en, done}));
endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
  import nef_pkg::*;
#(
  parameter int REPORT_W   = 32,
  parameter int SECT_BYTES = 512,
  localparam int ADDR_W    = $clog2(SECT_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [REPORT_W-1:0] report,
  input  logic                spare_mode,
  output logic                busy,
  output logic                done,
  output logic                ok,
  output logic [1:0]          err_class,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic                ram_rd_en,
  output logic                ram_wr_en,
  output logic [BYTE_W-1:0]   ram_wdata,
  input  logic [BYTE_W-1:0]   ram_rdata
);
  logic [REPORT_W-1:0] rep_q;
  logic                spare_q;
  ecc_fault_t          fault;
  logic                in_range;
  logic [BYTE_W-1:0]   mask;

  nef_decode #(.REPORT_W(REPORT_W), .SECT_BYTES(SECT_BYTES)) u_decode (
    .report    (rep_q),
    .spare_sel (spare_q),
    .fault     (fault),
    .in_range  (in_range)
  );

  nef_onehot #(.SEL_W(BIT_W)) u_mask (
    .sel  (fault.bitpos),
    .mask (mask)
  );

  nef_rmw_ctrl #(.REPORT_W(REPORT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .report     (report),
    .spare_mode (spare_mode),
    .rep_q      (rep_q),
    .spare_q    (spare_q),
    .fault      (fault),
    .in_range   (in_range),
    .mask       (mask),
    .busy       (busy),
    .done       (done),
    .ok         (ok),
    .err_class  (err_class),
    .ram_addr   (ram_addr),
    .ram_rd_en  (ram_rd_en),
    .ram_wr_en  (ram_wr_en),
    .ram_wdata  (ram_wdata),
    .ram_rdata  (ram_rdata)
  );
endmodule

// File: tb/nand_ecc_fixer_bench.sv
module nand_ecc_fixer_bench;
  localparam int CLK_P = 10;
  localparam int SECT  = 512;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] report = '0;
  logic        spare_mode = 1'b0;
  logic        busy, done, ok;
  logic [1:0]  err_class;
  logic [8:0]  ram_addr;
  logic        ram_rd_en, ram_wr_en;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;

  nand_ecc_fixer u_nand_ecc_fixer (
    .clk(clk), .rst_n(rst_n), .start(start), .report(report),
    .spare_mode(spare_mode), .busy(busy), .done(done), .ok(ok),
    .err_class(err_class), .ram_addr(ram_addr), .ram_rd_en(ram_rd_en),
    .ram_wr_en(ram_wr_en), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  logic [7:0] mem    [SECT];
  logic [7:0] golden [SECT];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SECT; i++) mem[i] <= 8'(i * 37 + 5);
    end else begin
      if (ram_wr_en) mem[ram_addr] <= ram_wdata;
      if (ram_rd_en) ram_rdata <= mem[ram_addr];
    end
  end

  typedef struct {
    logic       ok;
    logic [1:0] cls;
    int         addr;
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;

  task automatic chk(bit cond, string req, string what, int act, int expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk_main(int cls, int idx, int b);
    return 32'(cls & 3) | (32'(b & 7) << 4) | (32'(idx & 11'h7ff) << 7);
  endfunction

  function automatic logic [31:0] mk_spare(int cls, int idx, int b);
    return (32'(cls & 3) << 2) | (32'(b & 7) << 18) | (32'(idx & 15) << 21);
  endfunction

  // monitor: pops the scoreboard on every done
  always @(negedge clk) begin
    if (rst_n && ram_wr_en) wr_cnt++;
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "done without request", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(ok == e.ok, e.req, "ok", int'(ok), int'(e.ok));
        chk(err_class == e.cls, e.req, "err_class", int'(err_class), int'(e.cls));
        if (e.addr >= 0)
          chk(mem[e.addr] == e.val, e.req, "ram byte", int'(mem[e.addr]), int'(e.val));
      end
    end
  end

  // driver: one request; intr=1 pulses start mid-repair, scr=1 scrambles inputs after accept
  task automatic run(logic [31:0] rep, bit spare, string req, bit exp_ok, int exp_cls,
                     int idx, int b, bit corr, bit intr, bit scr, logic [31:0] other);
    exp_t e;
    int   n, rd_at, wr_at, wr0;
    if (corr) golden[idx] = golden[idx] ^ 8'(1 << b);
    e.ok = exp_ok; e.cls = 2'(exp_cls); e.req = req;
    e.addr = (idx < SECT) ? idx : -1;
    e.val  = (idx < SECT) ? golden[idx] : 8'h0;
    exp_q.push_back(e);
    wr0 = wr_cnt;
    @(negedge clk);
    start = 1'b1; report = rep; spare_mode = spare;
    @(negedge clk);
    start = 1'b0;
    if (scr) begin report = other; spare_mode = ~spare; end
    n = 1; rd_at = -1; wr_at = -1;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
      if (ram_rd_en) rd_at = n;
      if (ram_wr_en) wr_at = n;
      if (intr && n == 2) begin start = 1'b1; report = other; end
      if (intr && n == 3) begin start = 1'b0; end
    end
    chk(n == (corr ? 5 : 2), (corr ? "R7" : "R3"), "done latency", n, corr ? 5 : 2);
    if (corr) begin
      chk(rd_at == 2, "R7", "read cycle", rd_at, 2);
      chk(wr_at == 4, "R7", "write cycle", wr_at, 4);
    end
    @(negedge clk);
    chk(!done, "R7", "done pulse width", int'(done), 0);
    chk((wr_cnt - wr0) == (corr ? 1 : 0), req, "write count", wr_cnt - wr0, corr ? 1 : 0);
    report = '0; spare_mode = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < SECT; i++) golden[i] = 8'(i * 37 + 5);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!done && !ok && err_class == 2'd0 && !busy && !ram_rd_en && !ram_wr_en,
        "R10", "reset outputs", {done, ok, err_class, busy, ram_rd_en, ram_wr_en}, 0);

    // R3 clean, R1 main layout
    run(mk_main(0, 100, 3), 1'b0, "R3", 1'b1, 0, 100, 3, 1'b0, 1'b0, 1'b0, '0);
    // R4 single-bit repairs in main layout
    run(mk_main(1, 5, 0), 1'b0, "R4", 1'b1, 1, 5, 0, 1'b1, 1'b0, 1'b0, '0);
    run(mk_main(1, 511, 7), 1'b0, "R4", 1'b1, 1, 511, 7, 1'b1, 1'b0, 1'b0, '0);
    run(mk_main(1, 0, 6), 1'b0, "R4", 1'b1, 1, 0, 6, 1'b1, 1'b0, 1'b0, '0);
    // R5 multi-bit, no write
    run(mk_main(2, 20, 1), 1'b0, "R5", 1'b0, 2, 20, 1, 1'b0, 1'b0, 1'b0, '0);
    // R10 class and ok hold while idle
    repeat (5) @(negedge clk);
    chk(err_class == 2'd2 && !ok, "R10", "held result", {ok, err_class}, 2);
    // R6 check-area error
    run(mk_main(3, 21, 2), 1'b0, "R6", 1'b0, 3, 21, 2, 1'b0, 1'b0, 1'b0, '0);
    // R2 spare layout, main fields say multi
    run(mk_spare(1, 15, 5) | mk_main(2, 300, 1), 1'b1, "R2", 1'b1, 1, 15, 5,
        1'b1, 1'b0, 1'b0, '0);
    // R1 main layout, spare fields say check-area error
    run(mk_main(1, 300, 1) | mk_spare(3, 9, 2), 1'b0, "R1", 1'b1, 1, 300, 1,
        1'b1, 1'b0, 1'b0, '0);
    // R2 spare multi while main fields say single
    run(mk_spare(2, 4, 0) | mk_main(1, 4, 0), 1'b1, "R2", 1'b0, 2, 4, 0,
        1'b0, 1'b0, 1'b0, '0);
    // R11 index beyond sector
    run(mk_main(1, 700, 2), 1'b0, "R11", 1'b0, 1, 700, 2, 1'b0, 1'b0, 1'b0, '0);
    // R8 second start during repair targets byte 41
    run(mk_main(1, 40, 2), 1'b0, "R8", 1'b1, 1, 40, 2, 1'b1, 1'b1, 1'b0, mk_main(1, 41, 3));
    chk(mem[41] == golden[41], "R8", "intruder byte untouched", int'(mem[41]), int'(golden[41]));
    // R9 inputs changed right after accept
    run(mk_spare(1, 7, 1), 1'b1, "R9", 1'b1, 1, 7, 1, 1'b1, 1'b0, 1'b1, mk_main(1, 8, 4));
    chk(mem[8] == golden[8], "R9", "byte of scrambled report untouched", int'(mem[8]), int'(golden[8]));
    // R4 repairing the same bit again restores it
    run(mk_main(1, 5, 0), 1'b0, "R4", 1'b1, 1, 5, 0, 1'b1, 1'b0, 1'b0, '0);

    repeat (3) @(negedge clk);
    begin
      int bad = 0;
      for (int i = 0; i < SECT; i++) if (mem[i] !== golden[i]) bad++;
      chk(bad == 0, "R4", "sector contents mismatches", bad, 0);
    end
    chk(exp_q.size() == 0, "R8", "pending results", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule